// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates among five interrupt sources on behalf of a small 8-bit CPU core. The sources are, by index: external 0 (0), timer 0 (1), external 1 (2), timer 1 (3) and serial (4). Each source has its own enable bit and a one-bit level setting. A global enable bit gates every source. The core sees a single registered vector request. It accepts that request with an acknowledge pulse. It reports the end of a handler with a return strobe.

Two in-service flags record which levels have handlers running. A flag is set when the core accepts a request at that level. On a return strobe, the highest flag that is set is cleared. A handler at the high level can therefore nest over a low-level handler. Nothing can nest over a handler of its own level or a higher one.

Software sets the configuration through a small write port. Select 0 writes the enable register: bit k enables source k, and bit DATA_W-1 is the global enable. Select 1 writes the level register: bit k set to 1 makes source k high level, and 0 makes it low level.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Reset clears every enable, level and in-service bit, so no request is raised even while all source lines are active.
- R2: The vector presented for source index k is 0x0003 + 8·k (external 0 is 0x0003, timer 0 is 0x000B, external 1 is 0x0013, timer 1 is 0x001B, serial is 0x0023). `irq_lvl` shows the level of the presented source (1 = high).
- R3: Among requests of the same level, the lowest index wins: external 0, then timer 0, then external 1, then timer 1, then serial.
- R4: A source whose individual enable bit is 0 never produces a request.
- R5: When the global enable (enable register bit DATA_W-1) is 0, no source produces a request, whatever its individual enable bit.
- R6: When both a high-level and a low-level request are live, the high-level source is presented, regardless of the indices.
- R7: A high-level request is presented while a low-level handler is in service.
- R8: While a high-level handler is in service, no request is presented, whether low level or high level.
- R9: A request at the same level as the running handler is held back until that handler returns.
- R10: A return strobe clears only the highest in-service flag that is set. After a nested high-level handler returns, low-level requests stay blocked until a second return.
- R11: In the cycle after an acknowledge of a presented request, `irq_req` is low, so one pending request is never vectored twice.
- R12: A request reflects the source and register state of the previous cycle. It rises one cycle after the enabling write or the source edge, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | Level-sensitive source request lines, bit k = source k |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = enable register, 1 = level register |
| wr_data | input | DATA_W | Write data |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | VEC_W | Vector address of the presented source |
| irq_lvl | output | 1 | Level of the presented source, 1 = high |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from the current handler |

## Verification
The arbitration result passes through one output register. A change on a source line or a register write therefore shows on `irq_req` and `irq_vec` at the first clock edge after it. A return strobe frees the request path at its own edge, and the freed request appears one edge later. The bench drives on the falling edge and waits a fixed number of edges before sampling each result on a falling edge. It waits one edge for arbitration results. It waits two edges after a return or an acknowledge before checking whether a blocked request has surfaced. It also checks the low value in the cycle just after an acknowledge, and the still-low value in the cycle of the enabling write.

// File: rtl/nic_pkg.sv
package nic_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } nic_lvl_e;

   typedef enum logic {
      SEL_ENABLE = 1'b0,
      SEL_LEVEL  = 1'b1
   } nic_sel_e;

   localparam int unsigned NIC_LEVELS = 2;

endpackage

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [NUM_SRC-1:0] src_en,
   output logic [NUM_SRC-1:0] src_lvl,
   output logic               glb_en
);
   import nic_pkg::*;

   localparam int unsigned GLB_BIT = DATA_W - 1;

   logic wr_enable_reg;
   logic wr_level_reg;

   assign wr_enable_reg = wr_en && (nic_sel_e'(wr_sel) == SEL_ENABLE);
   assign wr_level_reg  = wr_en && (nic_sel_e'(wr_sel) == SEL_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_en <= '0;
         glb_en <= 1'b0;
      end else if (wr_enable_reg) begin
         src_en <= wr_data[NUM_SRC-1:0];
         glb_en <= wr_data[GLB_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_lvl <= '0;
      end else if (wr_level_reg) begin
         src_lvl <= wr_data[NUM_SRC-1:0];
      end
   end

endmodule

// File: rtl/nic_level_pick.sv
module nic_level_pick #(
   parameter int unsigned NUM_SRC = 5,
   parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   logic [NUM_SRC-1:0] grant;

   generate
      if (NUM_SRC == 1) begin : g_single
         assign grant = req;
      end else begin : g_chain
         logic [NUM_SRC:0] seen;
         assign seen[0] = 1'b0;
         for (genvar g = 0; g < NUM_SRC; g++) begin : g_stage
            assign grant[g]    = req[g] & ~seen[g];
            assign seen[g + 1] = seen[g] | req[g];
         end
      end
   endgenerate

   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) idx = idx | IDX_W'(i);
      end
   end

endmodule

// File: rtl/nic_in_service.sv
module nic_in_service (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_en,
   input  logic       set_lvl,
   input  logic       ret,
   output logic [1:0] active
);
   import nic_pkg::*;

   logic [1:0] active_nx;

   always_comb begin
      active_nx = active;
      if (ret) begin
         if (active[LVL_HI]) active_nx[LVL_HI] = 1'b0;
         else                active_nx[LVL_LO] = 1'b0;
      end
      if (set_en) active_nx[set_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active <= '0;
      else        active <= active_nx;
   end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic               irq_lvl,
   input  logic               irq_ack,
   input  logic               irq_ret
);
   import nic_pkg::*;

   localparam int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned VEC_TOP = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

   generate
      if (NUM_SRC < 1 || NUM_SRC >= DATA_W) begin : g_bad_src
         $error("NUM_SRC must be at least 1 and below DATA_W");
      end
      if (VEC_TOP >= (64'd1 << VEC_W)) begin : g_bad_vec
         $error("vector table does not fit VEC_W");
      end
      if (VEC_STRIDE == 0) begin : g_bad_stride
         $error("VEC_STRIDE must be nonzero");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] src_lvl;
   logic               glb_en;
   logic [1:0]         inserv;

   logic [NUM_SRC-1:0] live;
   logic [NUM_SRC-1:0] hi_live;
   logic [NUM_SRC-1:0] lo_live;
   logic               hi_any;
   logic               lo_any;
   logic [IDX_W-1:0]   hi_idx;
   logic [IDX_W-1:0]   lo_idx;

   logic               hi_ok;
   logic               lo_ok;
   logic               cand_valid;
   logic [IDX_W-1:0]   cand_idx;
   logic               cand_lvl;
   logic [VEC_W-1:0]   cand_vec;
   logic               take;

   nic_cfg_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .src_en  (src_en),
      .src_lvl (src_lvl),
      .glb_en  (glb_en)
   );

   assign live    = src_req & src_en & {NUM_SRC{glb_en}};
   assign hi_live = live & src_lvl;
   assign lo_live = live & ~src_lvl;

   nic_level_pick #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W)
   ) u_pick_hi (
      .req (hi_live),
      .any (hi_any),
      .idx (hi_idx)
   );

   nic_level_pick #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W)
   ) u_pick_lo (
      .req (lo_live),
      .any (lo_any),
      .idx (lo_idx)
   );

   assign hi_ok      = hi_any && !inserv[LVL_HI];
   assign lo_ok      = lo_any && !inserv[LVL_HI] && !inserv[LVL_LO];
   assign cand_valid = hi_ok || lo_ok;
   assign cand_idx   = hi_ok ? hi_idx : lo_idx;
   assign cand_lvl   = hi_ok ? LVL_HI : LVL_LO;
   assign cand_vec   = VEC_W'(VEC_BASE + VEC_STRIDE * int'(cand_idx));

   assign take = irq_ack && irq_req;

   nic_in_service u_inserv (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (take),
      .set_lvl (irq_lvl),
      .ret     (irq_ret),
      .active  (inserv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
      end else if (take) begin
         irq_req <= 1'b0;
      end else begin
         irq_req <= cand_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_vec <= VEC_W'(VEC_BASE);
         irq_lvl <= LVL_LO;
      end else if (cand_valid && !take) begin
         irq_vec <= cand_vec;
         irq_lvl <= cand_lvl;
      end
   end

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vec,
   input logic             irq_lvl,
   input logic             irq_ack,
   input logic             irq_ret,
   input logic [1:0]       inserv,
   input logic             glb_en
);
   localparam int unsigned VEC_TOP = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

   // R2: every presented vector is one of the table entries
   p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (int'(irq_vec) >= VEC_BASE) && (int'(irq_vec) <= VEC_TOP) &&
                  ((int'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0));

   // R5: no request unless the global enable was on in the previous cycle
   p_glb_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(glb_en));

   // R8: a running high-level handler blocks every request
   p_hi_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(inserv[1]) |-> !irq_req);

   // R9: a low-level request waits while a low-level handler runs
   p_lo_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_lvl) |-> !$past(inserv[0]));

   // R11: an accepted request is withdrawn in the next cycle
   p_ack_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !irq_req);

   // R10: a return with no accept clears the high flag and keeps the low one
   p_ret_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !(irq_ack && irq_req) && inserv[1]) |=>
         (!inserv[1] && (inserv[0] == $past(inserv[0]))));

endmodule

bind nest_irq_ctrl nic_checker #(
   .NUM_SRC    (NUM_SRC),
   .VEC_W      (VEC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE)
) u_nic_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq_req (irq_req),
   .irq_vec (irq_vec),
   .irq_lvl (irq_lvl),
   .irq_ack (irq_ack),
   .irq_ret (irq_ret),
   .inserv  (inserv),
   .glb_en  (glb_en)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;

   localparam int NS = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NS-1:0] src_req = '0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        irq_req;
   logic [15:0] irq_vec;
   logic        irq_lvl;
   logic        irq_ack = 1'b0;
   logic        irq_ret = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nest_irq_ctrl i_nest_irq_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_req (src_req),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .irq_req (irq_req),
      .irq_vec (irq_vec),
      .irq_lvl (irq_lvl),
      .irq_ack (irq_ack),
      .irq_ret (irq_ret)
   );

   function automatic logic [15:0] vec_of(int k);
      return 16'(3 + 8 * k);
   endfunction

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_req(string tag, bit exp_req);
      check(irq_req == exp_req, tag, int'(irq_req), int'(exp_req));
   endtask

   task automatic check_vec(string tag, int k, bit lvl);
      check(irq_req == 1'b1, {tag, " req"}, int'(irq_req), 1);
      check(irq_vec == vec_of(k), {tag, " vec"}, int'(irq_vec), int'(vec_of(k)));
      check(irq_lvl == lvl, {tag, " lvl"}, int'(irq_lvl), int'(lvl));
   endtask

   task automatic wr_reg(bit sel, logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   task automatic ret();
      irq_ret = 1'b1;
      tick();
      irq_ret = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src_req = '0;
      tick(2);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset();
      src_req = '1;
      tick(2);
      check_req("R1 reset leaves all sources masked", 1'b0);
      src_req = '0;
   endtask

   task automatic t_enables();
      src_req = 5'b00100;
      wr_reg(1'b0, 8'h1F);              // individual enables only
      tick(2);
      check_req("R5 global enable off masks all", 1'b0);
      wr_reg(1'b0, 8'h9B);              // global on, ext1 off
      tick(2);
      check_req("R4 disabled source ignored", 1'b0);
      wr_reg(1'b0, 8'h9F);
      check_req("R12 no request in write cycle", 1'b0);
      tick();
      check_vec("R12 R2 ext1 after one cycle", 2, 1'b0);
      src_req = '0;
      tick();
      check_req("R12 request follows source drop", 1'b0);
   endtask

   task automatic t_poll();
      wr_reg(1'b1, 8'h00);
      src_req = 5'b11111; tick();
      check_vec("R3 all low ext0 first", 0, 1'b0);
      src_req = 5'b11110; tick();
      check_vec("R3 timer0 next", 1, 1'b0);
      src_req = 5'b11000; tick();
      check_vec("R3 timer1 before serial", 3, 1'b0);
      src_req = 5'b10000; tick();
      check_vec("R2 serial vector", 4, 1'b0);
      src_req = '0; tick();
   endtask

   task automatic t_hi_first();
      wr_reg(1'b1, 8'h10);              // serial high
      src_req = 5'b11111; tick(2);
      check_vec("R6 high serial beats low ext0", 4, 1'b1);
      src_req = '0; tick();
   endtask

   task automatic t_nest();
      wr_reg(1'b1, 8'h10);
      src_req = 5'b00001; tick();
      check_vec("R2 ext0 low", 0, 1'b0);
      ack();
      check_req("R11 dropped after ack", 1'b0);
      src_req = 5'b00010; tick(2);
      check_req("R9 same level waits", 1'b0);
      src_req = 5'b10010; tick();
      check_vec("R7 high preempts low", 4, 1'b1);
      ack();
      check_req("R11 dropped after high ack", 1'b0);
      src_req = 5'b00011; tick(2);
      check_req("R8 low blocked under high", 1'b0);
      src_req = 5'b10011; tick(2);
      check_req("R8 high blocked under high", 1'b0);
      src_req = 5'b00011;
      ret(); tick(2);
      check_req("R10 first return keeps low flag", 1'b0);
      ret();
      check_req("R10 request not in return cycle", 1'b0);
      tick();
      check_vec("R10 R9 low resumes after second return", 0, 1'b0);
      src_req = '0;
      ack(); ret(); tick(2);
      check_req("R10 idle after final return", 1'b0);
   endtask

   initial begin
      do_reset();
      t_reset();
      t_enables();
      t_poll();
      t_hi_first();
      t_nest();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule